// File: doc/BRIEF.md
# External Bus Burst and Byte-Lane Controller

This block sits between a processor-side request port and a 32-bit external bus. It takes one request at a time. A request carries an address, a size code and a burst flag. The block turns it into one or more bus beats. For each beat it drives a word-aligned address, a transfer-size code, a burst indicator and four byte-lane enables. It holds the beat until the slave acknowledges it, then moves on to the next beat. After the final beat it pulses a completion flag.

A single transfer moves one byte, one half-word or one word. Its lanes start at the byte offset held in address bits [1:0]. A burst always moves whole words. It begins at the word selected by address bits [3:2] and climbs to word 3 of the 16-byte line without wrapping. A misaligned single request is refused with an error pulse and causes no bus activity. A remaining-byte count is reported throughout, so the requester can track progress.

Top module: `ebus_beat_ctrl`

## Requirements
- R1: After reset, bus_active, bus_burst, done and err are 0, bus_lane_en is 0000, bus_tsiz is 00 and bytes_left is 0.
- R2: For an accepted single request, bus_tsiz equals the request size code, where 01 is one byte, 10 is a half-word and 00 is a word.
- R3: Single-request lanes are big-endian: offset k enables bus_lane_en bit 3-k. A request enables size-many contiguous lanes starting at offset req_addr[1:0]. Examples: a half-word at offset 2 gives 0011, and a word gives 1111.
- R4: A single request is refused when its size code is 11, when a half-word sits at an odd offset, or when a word sits at a nonzero offset. A refused request makes err high for exactly the one cycle after acceptance, and bus_active stays 0.
- R5: During every burst beat, bus_tsiz is 00 and bus_lane_en is 1111. The request size code and address bits [1:0] are ignored.
- R6: A burst starts at word req_addr[3:2] and runs 4 - req_addr[3:2] beats. Beat addresses are word-aligned and rise by 4 per acknowledged beat, ending at word 3 of the line with no wrap. A single transfer presents req_addr with bits [1:0] cleared.
- R7: bus_burst is high for all beats of a burst that starts at word 0, and low for every other transfer.
- R8: When a transfer is accepted, bytes_left is set to its total byte count: 1, 2 or 4 for a single transfer, and 16, 12, 8 or 4 for a burst starting at word 0, 1, 2 or 3. It falls by 4 on each acknowledged burst beat that is not the last, and it is 0 when done is high.
- R9: done is high for exactly the one cycle after the acknowledge of the final beat. In that cycle bus_active is 0.
- R10: A request presented while a transfer is active is ignored. A request presented in any idle cycle, including the done cycle, is accepted and its first beat appears on the next cycle.
- R11: While the slave does not acknowledge, the current beat's address, lanes, size code and bytes_left stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Size code: 01 byte, 10 half-word, 00 word |
| req_burst | input | 1 | Request a line burst instead of a single transfer |
| slv_ack | input | 1 | Slave acknowledges the current beat |
| bus_active | output | 1 | A beat is being presented |
| bus_addr | output | 32 | Word-aligned beat address |
| bus_tsiz | output | 2 | Transfer-size code on the bus |
| bus_burst | output | 1 | Burst indicator (full-line burst only) |
| bus_lane_en | output | 4 | Byte-lane enables, bit 3 = data bits 31:24 |
| bytes_left | output | 5 | Bytes still to be transferred |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse for a misaligned request |

## Verification
A corrupted beat counter shows up as a wrong burst length. A burst then either stops before word 3 or runs past it, and the stray beat address appears on bus_addr within one acknowledge of the mistake. A wrong byte count is visible on bytes_left from the first beat, and it becomes a nonzero value alongside done at the end. A bad lane or size decode appears on bus_lane_en and bus_tsiz in the cycle right after acceptance. A stuck state appears either as a beat that never ends after its acknowledge or as a lost done pulse.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int ADDR_W     = 32;
    localparam int BUS_BYTES  = 4;
    localparam int LINE_WORDS = 4;
    localparam int OFF_W      = $clog2(BUS_BYTES);
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int BEAT_W     = $clog2(LINE_WORDS + 1);
    localparam int CNT_W      = $clog2(LINE_WORDS * BUS_BYTES + 1);

    localparam logic [1:0] TSZ_WORD = 2'b00;
    localparam logic [1:0] TSZ_BYTE = 2'b01;
    localparam logic [1:0] TSZ_HALF = 2'b10;

    typedef struct packed {
        logic                  active;
        logic [ADDR_W-1:0]     addr;
        logic [1:0]            tsiz;
        logic                  full;
        logic [BUS_BYTES-1:0]  lanes;
        logic [BEAT_W-1:0]     beats_left;
        logic [CNT_W-1:0]      bytes_left;
        logic                  done;
        logic                  err;
    } ctl_t;

endpackage

// File: rtl/ebus_lane_dec.sv
module ebus_lane_dec
    import ebus_pkg::*;
(
    input  logic [OFF_W-1:0]     off,
    input  logic [1:0]           size,
    output logic [BUS_BYTES-1:0] lanes,
    output logic [CNT_W-1:0]     nbytes,
    output logic                 bad
);

    int n;

    always_comb begin
        case (size)
            TSZ_BYTE: n = 1;
            TSZ_HALF: n = 2;
            TSZ_WORD: n = BUS_BYTES;
            default:  n = 0;
        endcase
    end

    assign nbytes = CNT_W'(n);
    assign bad    = (n == 0) || ((int'(off) & (n - 1)) != 0);

    // offset i drives lane bit BUS_BYTES-1-i (big-endian)
    generate
        for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
            assign lanes[BUS_BYTES-1-i] = (n != 0) && (i >= int'(off)) && (i < int'(off) + n);
        end
    endgenerate

endmodule

// File: rtl/ebus_burst_plan.sv
module ebus_burst_plan
    import ebus_pkg::*;
(
    input  logic [WIDX_W-1:0] start,
    output logic [BEAT_W-1:0] beats,
    output logic [CNT_W-1:0]  total,
    output logic              full
);

    localparam int SPAN = LINE_WORDS;

    assign beats = BEAT_W'(SPAN - int'(start));
    assign total = CNT_W'((SPAN - int'(start)) * BUS_BYTES);
    assign full  = (start == '0);

endmodule

// File: rtl/ebus_beat_ctrl.sv
module ebus_beat_ctrl
    import ebus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_burst,
    input  logic                 slv_ack,
    output logic                 bus_active,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [1:0]           bus_tsiz,
    output logic                 bus_burst,
    output logic [BUS_BYTES-1:0] bus_lane_en,
    output logic [CNT_W-1:0]     bytes_left,
    output logic                 done,
    output logic                 err
);

    ctl_t ctl_d, ctl_q;

    logic [BUS_BYTES-1:0] dec_lanes;
    logic [CNT_W-1:0]     dec_bytes;
    logic                 dec_bad;
    logic [BEAT_W-1:0]    plan_beats;
    logic [CNT_W-1:0]     plan_total;
    logic                 plan_full;
    logic [ADDR_W-1:0]    req_word;

    assign req_word = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    ebus_lane_dec i_lane_dec (
        .off    (req_addr[OFF_W-1:0]),
        .size   (req_size),
        .lanes  (dec_lanes),
        .nbytes (dec_bytes),
        .bad    (dec_bad)
    );

    ebus_burst_plan i_burst_plan (
        .start (req_addr[OFF_W+WIDX_W-1:OFF_W]),
        .beats (plan_beats),
        .total (plan_total),
        .full  (plan_full)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        if (!ctl_q.active) begin
            if (req_valid) begin
                if (req_burst) begin
                    ctl_d.active     = 1'b1;
                    ctl_d.addr       = req_word;
                    ctl_d.tsiz       = TSZ_WORD;
                    ctl_d.full       = plan_full;
                    ctl_d.lanes      = '1;
                    ctl_d.beats_left = plan_beats;
                    ctl_d.bytes_left = plan_total;
                end else if (dec_bad) begin
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.active     = 1'b1;
                    ctl_d.addr       = req_word;
                    ctl_d.tsiz       = req_size;
                    ctl_d.full       = 1'b0;
                    ctl_d.lanes      = dec_lanes;
                    ctl_d.beats_left = BEAT_W'(1);
                    ctl_d.bytes_left = dec_bytes;
                end
            end
        end else if (slv_ack) begin
            if (ctl_q.beats_left == BEAT_W'(1)) begin
                ctl_d.active     = 1'b0;
                ctl_d.done       = 1'b1;
                ctl_d.tsiz       = TSZ_WORD;
                ctl_d.full       = 1'b0;
                ctl_d.lanes      = '0;
                ctl_d.beats_left = '0;
                ctl_d.bytes_left = '0;
            end else begin
                ctl_d.addr       = ctl_q.addr + ADDR_W'(BUS_BYTES);
                ctl_d.beats_left = ctl_q.beats_left - BEAT_W'(1);
                ctl_d.bytes_left = ctl_q.bytes_left - CNT_W'(BUS_BYTES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_active  = ctl_q.active;
    assign bus_addr    = ctl_q.addr;
    assign bus_tsiz    = ctl_q.tsiz;
    assign bus_burst   = ctl_q.full;
    assign bus_lane_en = ctl_q.lanes;
    assign bytes_left  = ctl_q.bytes_left;
    assign done        = ctl_q.done;
    assign err         = ctl_q.err;

endmodule

// File: rtl/ebus_beat_chk.sv
module ebus_beat_chk
    import ebus_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 slv_ack,
    input logic                 bus_active,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [1:0]           bus_tsiz,
    input logic                 bus_burst,
    input logic [BUS_BYTES-1:0] bus_lane_en,
    input logic [CNT_W-1:0]     bytes_left,
    input logic                 done,
    input logic                 err
);

    // R1
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> (bus_lane_en == '0 && !bus_burst));

    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_active);

    // R5
    burst_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst |-> (bus_tsiz == TSZ_WORD && bus_lane_en == '1));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && slv_ack && bytes_left > CNT_W'(BUS_BYTES))
        |=> (bus_active && bus_addr == $past(bus_addr) + ADDR_W'(BUS_BYTES)));

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bytes_left == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && slv_ack && bytes_left <= CNT_W'(BUS_BYTES)) |=> (done && !bus_active));

    // R11
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !slv_ack) |=> (bus_active && $stable(bus_addr) && $stable(bus_lane_en)
                                      && $stable(bus_tsiz) && $stable(bytes_left)));

endmodule

bind ebus_beat_ctrl ebus_beat_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slv_ack     (slv_ack),
    .bus_active  (bus_active),
    .bus_addr    (bus_addr),
    .bus_tsiz    (bus_tsiz),
    .bus_burst   (bus_burst),
    .bus_lane_en (bus_lane_en),
    .bytes_left  (bytes_left),
    .done        (done),
    .err         (err)
);

// File: tb/test_ebus_beat_ctrl.sv
module test_ebus_beat_ctrl;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_burst = 1'b0;
    logic        slv_ack = 1'b0;
    logic        bus_active;
    logic [31:0] bus_addr;
    logic [1:0]  bus_tsiz;
    logic        bus_burst;
    logic [3:0]  bus_lane_en;
    logic [4:0]  bytes_left;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ebus_beat_ctrl i_ebus_beat_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_burst(req_burst), .slv_ack(slv_ack),
        .bus_active(bus_active), .bus_addr(bus_addr), .bus_tsiz(bus_tsiz),
        .bus_burst(bus_burst), .bus_lane_en(bus_lane_en), .bytes_left(bytes_left),
        .done(done), .err(err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        burst;
        logic        bad;
        logic [1:0]  tsiz;
        logic [3:0]  lanes;
        logic [2:0]  beats;
        logic [4:0]  total;
        logic        full;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 2'b01, 1'b0, 1'b0, 2'b01, 4'b1000, 3'd1, 5'd1,  1'b0},
        '{32'h0000_1003, 2'b01, 1'b0, 1'b0, 2'b01, 4'b0001, 3'd1, 5'd1,  1'b0},
        '{32'h0000_1001, 2'b01, 1'b0, 1'b0, 2'b01, 4'b0100, 3'd1, 5'd1,  1'b0},
        '{32'h0000_1002, 2'b10, 1'b0, 1'b0, 2'b10, 4'b0011, 3'd1, 5'd2,  1'b0},
        '{32'h0000_1000, 2'b10, 1'b0, 1'b0, 2'b10, 4'b1100, 3'd1, 5'd2,  1'b0},
        '{32'h0000_1004, 2'b00, 1'b0, 1'b0, 2'b00, 4'b1111, 3'd1, 5'd4,  1'b0},
        '{32'h0000_1001, 2'b10, 1'b0, 1'b1, 2'b00, 4'b0000, 3'd0, 5'd0,  1'b0},
        '{32'h0000_1002, 2'b00, 1'b0, 1'b1, 2'b00, 4'b0000, 3'd0, 5'd0,  1'b0},
        '{32'h0000_1000, 2'b11, 1'b0, 1'b1, 2'b00, 4'b0000, 3'd0, 5'd0,  1'b0},
        '{32'h0000_2000, 2'b00, 1'b1, 1'b0, 2'b00, 4'b1111, 3'd4, 5'd16, 1'b1},
        '{32'h0000_2004, 2'b00, 1'b1, 1'b0, 2'b00, 4'b1111, 3'd3, 5'd12, 1'b0},
        '{32'h0000_2008, 2'b00, 1'b1, 1'b0, 2'b00, 4'b1111, 3'd2, 5'd8,  1'b0},
        '{32'h0000_200C, 2'b00, 1'b1, 1'b0, 2'b00, 4'b1111, 3'd1, 5'd4,  1'b0},
        '{32'h0000_201B, 2'b01, 1'b1, 1'b0, 2'b00, 4'b1111, 3'd2, 5'd8,  1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] ea;
        ea = v.addr & ~32'h3;
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_burst = v.burst;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.bad) begin
            chk("R4 err pulse", 32'(err), 32'd1);
            chk("R4 no bus", 32'(bus_active), 32'd0);
            @(negedge clk);
            chk("R4 err width", 32'(err), 32'd0);
            chk("R4 still idle", 32'(bus_active), 32'd0);
        end else begin
            for (int b = 0; b < int'(v.beats); b++) begin
                chk("R6 beat addr", bus_addr, ea + 32'(4 * b));
                chk("R2 R5 tsiz", 32'(bus_tsiz), 32'(v.tsiz));
                chk("R3 R5 lanes", 32'(bus_lane_en), 32'(v.lanes));
                chk("R7 burst flag", 32'(bus_burst), 32'(v.full));
                chk("R8 bytes left", 32'(bytes_left), 32'(v.total) - 32'(4 * b));
                @(negedge clk);
                chk("R11 hold addr", bus_addr, ea + 32'(4 * b));
                chk("R11 hold bytes", 32'(bytes_left), 32'(v.total) - 32'(4 * b));
                slv_ack = 1'b1;
                @(negedge clk);
                slv_ack = 1'b0;
            end
            chk("R9 done", 32'(done), 32'd1);
            chk("R8 zero at done", 32'(bytes_left), 32'd0);
            chk("R9 idle at done", 32'(bus_active), 32'd0);
            @(negedge clk);
            chk("R9 done width", 32'(done), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active", 32'(bus_active), 32'd0);
        chk("R1 lanes", 32'(bus_lane_en), 32'd0);
        chk("R1 bytes", 32'(bytes_left), 32'd0);
        chk("R1 done err", 32'({done, err, bus_burst}), 32'd0);
        chk("R1 tsiz", 32'(bus_tsiz), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: request during an active burst is ignored
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_3000; req_burst = 1'b1; req_size = 2'b00;
        @(negedge clk);
        req_addr = 32'h0000_4001; req_burst = 1'b0; req_size = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 addr kept", bus_addr, 32'h0000_3000);
        chk("R10 bytes kept", 32'(bytes_left), 32'd16);
        chk("R10 lanes kept", 32'(bus_lane_en), 32'hF);
        for (int b = 0; b < 4; b++) begin
            chk("R10 R6 beat", bus_addr, 32'h0000_3000 + 32'(4 * b));
            slv_ack = 1'b1;
            if (b == 3) begin
                // request offered in the done cycle: must be accepted
                req_valid = 1'b1; req_addr = 32'h0000_5002; req_size = 2'b10; req_burst = 1'b0;
            end
            @(negedge clk);
            slv_ack = 1'b0;
        end
        chk("R9 done after burst", 32'(done), 32'd1);
        chk("R6 no wrap", 32'(bus_active), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 accepted after done", 32'(bus_active), 32'd1);
        chk("R10 new addr", bus_addr, 32'h0000_5000);
        chk("R3 new lanes", 32'(bus_lane_en), 32'b0011);
        slv_ack = 1'b1;
        @(negedge clk);
        slv_ack = 1'b0;
        chk("R9 single done", 32'(done), 32'd1);
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule